// File: doc/BRIEF.md
# Spread-Spectrum Watermark Leakage Generator

This block emits a pseudo-random watermark bit on every enabled clock cycle and uses that bit to decide whether a bank of toggling registers switches. The bit comes from a 32-bit maximal-length linear feedback shift register. The bank holds sixteen 16-bit circular registers, each preset to an alternating bit pattern. In a cycle where the watermark bit is one, every register in the bank rotates, so all 256 bits toggle. In a cycle where the bit is zero, the bank keeps its value. The switching activity therefore follows the pseudo-random sequence. A verifier who knows the polynomial and the seed can regenerate that sequence and correlate it with the measured supply current.

The seed port binds the sequence to an identity, for example part of a signature. The full generator state and the whole bank content are brought out. This keeps synthesis from removing the toggling logic and lets the sequence be inspected.

Top module: `wm_leak_gen`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, the generator state becomes the default seed 32'hACE1_0001. Every bank register becomes 16'hAAAA, meaning bit i is 1 exactly when i is odd.
- R2: On a rising edge with `en` high and `seed_load` low, the generator state s becomes {s[30:0], s[31]^s[21]^s[1]^s[0]}. These are taps 32, 22, 2 and 1 in Fibonacci form, and the bit shifted out is s[31].
- R3: On a rising edge where `wm_bit` is 1, each bank register rotates left by one position ({r[14:0], r[15]}), so all of its bits invert. On any other edge the bank is unchanged.
- R4: `wm_bit` equals `prng_state[31]` when `en` is high and `seed_load` is low, and is 0 otherwise.
- R5: On a rising edge with `en` low and `seed_load` low, `prng_state` and `bank_bits` are unchanged.
- R6: Loading an all-zero seed puts the default seed 32'hACE1_0001 into the generator instead, so `prng_state` is never zero.
- R7: On a rising edge with `seed_load` high, the generator state becomes `seed_val` (subject to R6), whatever the value of `en`. The bank holds during that cycle.
- R8: Bank register k appears at `bank_bits[16k+15:16k]`, k = 0..15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advances the generator and permits bank activity |
| seed_load | input | 1 | Loads `seed_val` into the generator |
| seed_val | input | 32 | Seed value to load |
| wm_bit | output | 1 | Current watermark bit that gates the bank |
| prng_state | output | 32 | Full generator state |
| bank_bits | output | 256 | Concatenated contents of the toggle bank |

## Verification
The bench runs the generator free from the default seed for more than a thousand cycles. This separates a wrong tap set or shift direction from a correct one, because any difference in the stream shows up within a few dozen steps. A second long run starts from a caller seed, which shows that the seed fully decides the sequence. Stretches with a random enable pattern check that hold cycles freeze both the generator and the bank and force the bit low. Seed loads are applied with the enable both high and low, and with a zero value, to cover load priority and the lock-up guard. A parity model of the bank, which counts rotations, confirms that the bank switches on exactly the cycles where the bit is one.

// File: rtl/wm_pkg.sv
package wm_pkg;

  // Action applied to the generator on the next rising edge
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_LOAD = 2'd2
  } lfsr_act_e;

endpackage

// File: rtl/wm_lfsr.sv
module wm_lfsr
  import wm_pkg::*;
#(
  parameter int          W            = 32,
  parameter logic [W-1:0] TAP_MASK    = 32'h8020_0003,
  parameter logic [W-1:0] DEFAULT_SEED = 32'hACE1_0001
) (
  input  logic           clk,
  input  logic           rst,
  input  lfsr_act_e      act,
  input  logic [W-1:0]   seed_val,
  output logic [W-1:0]   state,
  output logic           out_bit
);

  // One Fibonacci step: shift towards the MSB, feedback enters at bit 0
  function automatic logic [W-1:0] lfsr_advance(input logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAP_MASK)};
  endfunction

  // An all-zero state would lock the register; substitute the default
  function automatic logic [W-1:0] seed_fix(input logic [W-1:0] v);
    return (v == '0) ? DEFAULT_SEED : v;
  endfunction

  logic [W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= DEFAULT_SEED;
    end else begin
      unique case (act)
        ACT_LOAD: state_q <= seed_fix(seed_val);
        ACT_STEP: state_q <= lfsr_advance(state_q);
        default:  state_q <= state_q;
      endcase
    end
  end

  assign state   = state_q;
  assign out_bit = state_q[W-1];

endmodule

// File: rtl/wm_toggle_bank.sv
module wm_toggle_bank #(
  parameter int N = 16,
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rotate,
  output logic [N*W-1:0] bits
);

  // Bit i is set when i is odd, so a one-place rotation flips every bit
  function automatic logic [W-1:0] alt_pattern();
    logic [W-1:0] p;
    for (int i = 0; i < W; i++) p[i] = 1'(i % 2);
    return p;
  endfunction

  function automatic logic [W-1:0] rotl1(input logic [W-1:0] r);
    return {r[W-2:0], r[W-1]};
  endfunction

  for (genvar k = 0; k < N; k++) begin : g_reg
    logic [W-1:0] r_q;
    always_ff @(posedge clk) begin
      if (rst)         r_q <= alt_pattern();
      else if (rotate) r_q <= rotl1(r_q);
    end
    assign bits[k*W +: W] = r_q;
  end

endmodule

// File: rtl/wm_leak_gen.sv
module wm_leak_gen
  import wm_pkg::*;
#(
  parameter int                LFSR_W       = 32,
  parameter logic [LFSR_W-1:0] TAP_MASK     = 32'h8020_0003,
  parameter logic [LFSR_W-1:0] DEFAULT_SEED = 32'hACE1_0001,
  parameter int                BANK_N       = 16,
  parameter int                BANK_W       = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     seed_load,
  input  logic [LFSR_W-1:0]        seed_val,
  output logic                     wm_bit,
  output logic [LFSR_W-1:0]        prng_state,
  output logic [BANK_N*BANK_W-1:0] bank_bits
);

  localparam int BANK_BITS = BANK_N * BANK_W;

  lfsr_act_e act;
  logic      raw_bit;
  logic      step_evt;

  // Load wins over stepping
  always_comb begin
    if (seed_load) act = ACT_LOAD;
    else if (en)   act = ACT_STEP;
    else           act = ACT_HOLD;
  end

  assign step_evt = (act == ACT_STEP);

  wm_lfsr #(
    .W           (LFSR_W),
    .TAP_MASK    (TAP_MASK),
    .DEFAULT_SEED(DEFAULT_SEED)
  ) u_lfsr (
    .clk     (clk),
    .rst     (rst),
    .act     (act),
    .seed_val(seed_val),
    .state   (prng_state),
    .out_bit (raw_bit)
  );

  assign wm_bit = step_evt & raw_bit;

  logic [BANK_BITS-1:0] bank_q;

  wm_toggle_bank #(
    .N(BANK_N),
    .W(BANK_W)
  ) u_bank (
    .clk   (clk),
    .rst   (rst),
    .rotate(wm_bit),
    .bits  (bank_q)
  );

  assign bank_bits = bank_q;

endmodule

// File: rtl/wm_leak_gen_chk.sv
module wm_leak_gen_chk #(
  parameter int W  = 32,
  parameter int BW = 256
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          seed_load,
  input logic [W-1:0]  seed_val,
  input logic          wm_bit,
  input logic [W-1:0]  prng_state,
  input logic [BW-1:0] bank_bits
);

  p_bit_gated_r4: assert property (@(posedge clk) disable iff (rst)
    (!en || seed_load) |-> !wm_bit);

  p_hold_off_r5: assert property (@(posedge clk) disable iff (rst)
    (!en && !seed_load) |=> ($stable(prng_state) && $stable(bank_bits)));

  p_shift_r2: assert property (@(posedge clk) disable iff (rst)
    (en && !seed_load) |=> (prng_state[W-1:1] == $past(prng_state[W-2:0])));

  p_bank_flip_r3: assert property (@(posedge clk) disable iff (rst)
    wm_bit |=> (bank_bits == ~$past(bank_bits)));

  p_bank_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !wm_bit |=> $stable(bank_bits));

  p_load_r7: assert property (@(posedge clk) disable iff (rst)
    (seed_load && seed_val != '0) |=> (prng_state == $past(seed_val)));

  p_no_lockup_r6: assert property (@(posedge clk) disable iff (rst)
    prng_state != '0);

endmodule

bind wm_leak_gen wm_leak_gen_chk #(
  .W (LFSR_W),
  .BW(BANK_N*BANK_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .seed_load (seed_load),
  .seed_val  (seed_val),
  .wm_bit    (wm_bit),
  .prng_state(prng_state),
  .bank_bits (bank_bits)
);

// File: tb/wm_leak_gen_bench.sv
module wm_leak_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] DEF_SEED = 32'hACE1_0001;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic         seed_load = 1'b0;
  logic [31:0]  seed_val = '0;
  logic         wm_bit;
  logic [31:0]  prng_state;
  logic [255:0] bank_bits;

  int vectors = 0;
  int miscompares = 0;

  // Model: queue front is the oldest bit (state MSB); rotation count for bank parity
  bit q[$];
  int rot_count = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wm_leak_gen u_wm_leak_gen (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .seed_load (seed_load),
    .seed_val  (seed_val),
    .wm_bit    (wm_bit),
    .prng_state(prng_state),
    .bank_bits (bank_bits)
  );

  function automatic void model_set(input logic [31:0] v);
    q.delete();
    for (int i = 31; i >= 0; i--) q.push_back(v[i]);
  endfunction

  function automatic logic [31:0] model_word();
    logic [31:0] w;
    for (int i = 0; i < 32; i++) w[31-i] = q[i];
    return w;
  endfunction

  function automatic void report(input string tag, input logic [255:0] act, input logic [255:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endfunction

  function automatic void compare_all(input string tag);
    logic [255:0] eb;
    logic [15:0]  pat;
    bit           ew;
    pat = (rot_count % 2 == 0) ? 16'hAAAA : 16'h5555;
    for (int k = 0; k < 16; k++) eb[k*16 +: 16] = pat;
    ew = (en && !seed_load) ? q[0] : 1'b0;
    report({tag, " R2 state"}, 256'(prng_state), 256'(model_word()));
    report({tag, " R3 R8 bank"}, bank_bits, eb);
    report({tag, " R4 wm_bit"}, 256'(wm_bit), 256'(ew));
  endfunction

  // Drive at negedge, compare after settling, advance model at posedge
  task automatic step(input bit e, input bit ld, input logic [31:0] sv, input string tag);
    bit fb;
    @(negedge clk);
    en = e; seed_load = ld; seed_val = sv;
    #1;
    compare_all(tag);
    @(posedge clk);
    if (ld) begin
      model_set((sv == 32'h0) ? DEF_SEED : sv);
    end else if (e) begin
      if (q[0]) rot_count++;
      fb = q[0] ^ q[10] ^ q[30] ^ q[31];
      void'(q.pop_front());
      q.push_back(fb);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_set(DEF_SEED);
    rot_count = 0;
    #1;
    compare_all("R1 reset");

    // Free run from the default seed
    for (int i = 0; i < 1200; i++) step(1'b1, 1'b0, '0, "R2 R3 free-run");

    // Random enable: holds must freeze state and bank
    for (int i = 0; i < 300; i++) step(1'($urandom_range(0, 1)), 1'b0, '0, "R5 random-enable");

    // Load with enable low, then run from the caller seed
    step(1'b0, 1'b1, 32'h1234_5678, "R7 load-disabled");
    step(1'b0, 1'b0, '0, "R7 after-load");
    for (int i = 0; i < 1100; i++) step(1'b1, 1'b0, '0, "R2 seeded-run");

    // Load priority over enable
    step(1'b1, 1'b1, 32'h8000_0000, "R7 load-priority");
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, '0, "R2 R3 msb-seed");

    // Zero seed falls back to default
    step(1'b1, 1'b1, 32'h0, "R6 zero-seed");
    step(1'b0, 1'b0, '0, "R6 after-zero");
    for (int i = 0; i < 60; i++) step(1'b1, 1'b0, '0, "R6 default-run");

    // Reset mid-run
    @(negedge clk);
    rst = 1'b1; en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0; en = 1'b0;
    model_set(DEF_SEED);
    rot_count = 0;
    #1;
    compare_all("R1 re-reset");
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, '0, "R1 R2 post-reset");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule